// File: doc/BRIEF.md
# Event Routing Channel

This block is a single channel of a peripheral event fabric. A 6-bit selector picks one of 63 generator lines (selector value zero connects nothing). The chosen line then takes one of three routes: sampled once by the channel clock, passed through a two-stage synchronizer into the channel clock domain, or forwarded combinationally with no clocking at all. On the two clocked routes a configurable edge detector turns the line into one-cycle event pulses.

Settings sit in one 32-bit configuration word, always written whole. The channel also drives a clock-request output so a clock controller can run the channel clock only on demand, and it shuts itself down in standby unless told to keep running. Instances whose index parameter is 4 or more can only use the combinational route.

Top module: `evt_route_chan`

## Requirements
- R1: After reset the configuration reads 0x00008000 (on-demand set, all else zero), and `evt_o`, `busy_o` and `clk_req_o` are low.
- R2: A write stores only bits 15, 14, 11:10, 9:8 and 5:0; all other bits read back as zero.
- R3: Generator selector (bits 5:0) value 0 connects no line: no event, busy low, clock request low. For a non-zero selector, only line `gen_i[sel]` affects the channel.
- R4: Route field (bits 9:8) = 0 samples the line with one register; a change present before clock edge k gives a one-cycle `evt_o` pulse in the cycle after edge k+1.
- R5: Route field = 1 passes the line through two synchronizer flops; a change present before edge k gives a one-cycle pulse in the cycle after edge k+2.
- R6: Edge field (bits 11:10) on the clocked routes: 0 no events, 1 rising only, 2 falling only, 3 both.
- R7: Route field = 3 is reserved: no events, busy low, clock request low.
- R8: Route field = 2 forwards the selected line combinationally to `evt_o`; the edge field has no effect.
- R9: With parameter CHAN_IDX of 4 or more the route is forced to 2 on every write, and reads back as 2.
- R10: With bit 14 clear and `standby_i` high the channel is stopped: no events, busy low, clock request low. With bit 14 set it operates normally in standby.
- R11: Bit 15 clear holds `clk_req_o` high whenever the channel is running with a non-zero selector and a non-reserved route; bit 15 set makes `clk_req_o` follow `busy_o`.
- R12: On the clocked routes `busy_o` rises as soon as a qualifying change appears on the selected line and stays high through the cycle the pulse is issued, then falls.
- R13: A configuration write clears the edge history, so no event results from the write itself even when the selected line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Full-word configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| gen_i | input | 63 | Generator lines, indexed 1 to 63 |
| standby_i | input | 1 | Standby sleep indication |
| evt_o | output | 1 | Channel event output |
| busy_o | output | 1 | Event in flight on a clocked route |
| clk_req_o | output | 1 | Channel clock request |

## Verification
The hardest state to reach is the moment right after a reconfiguration with the newly selected line already high, where stale history could fake an edge. The bench raises the line first, rewrites the configuration on both clocked routes, and watches the following cycles for a spurious pulse. The rest is a full sweep over route, edge mode, on-demand setting and several generator indices, driving both transitions and checking output, busy and clock request cycle by cycle against latencies computed from the route.

// File: rtl/evt_route_pkg.sv
`timescale 1ns/1ps
package evt_route_pkg;
  localparam int CFG_W = 32;
  localparam int SEL_W = 6;
  localparam logic [CFG_W-1:0] CFG_MASK  = 32'h0000_CF3F;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_8000;

  typedef enum logic [1:0] {
    ROUTE_SYNC   = 2'd0,
    ROUTE_RESYNC = 2'd1,
    ROUTE_ASYNC  = 2'd2,
    ROUTE_RSVD   = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef struct packed {
    logic             on_demand;
    logic             run_stby;
    edge_e            edge_sel;
    route_e           route;
    logic [SEL_W-1:0] gen_sel;
  } chan_cfg_t;

  function automatic chan_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    chan_cfg_t c;
    c.on_demand = w[15];
    c.run_stby  = w[14];
    c.edge_sel  = edge_e'(w[11:10]);
    c.route     = route_e'(w[9:8]);
    c.gen_sel   = w[SEL_W-1:0];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input chan_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[15]         = c.on_demand;
    w[14]         = c.run_stby;
    w[11:10]      = c.edge_sel;
    w[9:8]        = c.route;
    w[SEL_W-1:0]  = c.gen_sel;
    return w;
  endfunction
endpackage

// File: rtl/evt_cfg_reg.sv
`timescale 1ns/1ps
module evt_cfg_reg
  import evt_route_pkg::*;
#(
  parameter int CHAN_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output chan_cfg_t        cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  localparam bit ASYNC_ONLY = (CHAN_IDX >= 4);

  chan_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_unpack(wdata_i);
    if (ASYNC_ONLY) cfg_d.route = ROUTE_ASYNC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= cfg_unpack(CFG_RESET);
    else if (we_i) cfg_q <= cfg_d;
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = cfg_pack(cfg_q);

  // R2
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[31:16] == '0) && (rdata_o[13:12] == '0) && (rdata_o[7:6] == '0)
             && (rdata_o[5:0] == $past(wdata_i[5:0])) && (rdata_o[15:14] == $past(wdata_i[15:14])));

  // R9
  route_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ASYNC_ONLY && we_i |=> rdata_o[9:8] == 2'd2);
endmodule

// File: rtl/evt_gen_mux.sv
`timescale 1ns/1ps
module evt_gen_mux #(
  parameter int NUM_GEN = 63,
  parameter int SEL_W   = 6
) (
  input  logic [NUM_GEN:1]  gen_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              sig_o
);
  always_comb begin
    sig_o = 1'b0;
    for (int i = 1; i <= NUM_GEN; i++) begin
      if (sel_i == SEL_W'(i)) sig_o = gen_i[i];
    end
  end
endmodule

// File: rtl/evt_edge_det.sv
`timescale 1ns/1ps
module evt_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic resync_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic sig_i,
  output logic evt_o,
  output logic busy_o
);
  localparam int D = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [D-1:0] stg_q, vld_q;
  logic         hist_q, hist_v_q, evt_q;
  logic         d, d_v, det;

  function automatic logic qual(input logic a, input logic b, input logic r, input logic f);
    return (r & a & ~b) | (f & ~a & b);
  endfunction

  assign d   = resync_i ? stg_q[D-1] : stg_q[0];
  assign d_v = resync_i ? vld_q[D-1] : vld_q[0];
  assign det = en_i & d_v & hist_v_q & qual(d, hist_q, rise_en_i, fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0; vld_q <= '0; hist_q <= 1'b0; hist_v_q <= 1'b0; evt_q <= 1'b0;
    end else if (clr_i) begin
      stg_q <= '0; vld_q <= '0; hist_q <= 1'b0; hist_v_q <= 1'b0; evt_q <= 1'b0;
    end else if (en_i) begin
      stg_q    <= {stg_q[D-2:0], sig_i};
      vld_q    <= {vld_q[D-2:0], 1'b1};
      hist_q   <= d;
      hist_v_q <= d_v;
      evt_q    <= det;
    end else begin
      evt_q <= 1'b0;
    end
  end

  // pending change anywhere between the input and the history flop
  logic pend;
  always_comb begin
    pend = qual(sig_i, hist_q, rise_en_i, fall_en_i);
    for (int k = 0; k < D; k++) begin
      if (resync_i || k == 0)
        pend = pend | (vld_q[k] & qual(stg_q[k], hist_q, rise_en_i, fall_en_i));
    end
  end

  assign evt_o  = evt_q;
  assign busy_o = en_i & ((hist_v_q & pend) | evt_q);

  // R13
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !evt_o);

  // R12
  busy_before_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> $past(busy_o));
endmodule

// File: rtl/evt_route_chan.sv
`timescale 1ns/1ps
module evt_route_chan
  import evt_route_pkg::*;
#(
  parameter int CHAN_IDX    = 0,
  parameter int NUM_GEN     = 63,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  input  logic [NUM_GEN:1]   gen_i,
  input  logic               standby_i,
  output logic               evt_o,
  output logic               busy_o,
  output logic               clk_req_o
);
  chan_cfg_t cfg;
  logic      sel_sig, chan_en, route_ok, clocked, det_evt, det_busy;

  evt_cfg_reg #(.CHAN_IDX(CHAN_IDX)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  evt_gen_mux #(.NUM_GEN(NUM_GEN), .SEL_W(SEL_W)) u_mux (
    .gen_i (gen_i),
    .sel_i (cfg.gen_sel),
    .sig_o (sel_sig)
  );

  assign chan_en  = !(standby_i && !cfg.run_stby);
  assign route_ok = (cfg.gen_sel != '0) && (cfg.route != ROUTE_RSVD);
  assign clocked  = (cfg.route == ROUTE_SYNC) || (cfg.route == ROUTE_RESYNC);

  evt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_we_i),
    .en_i      (chan_en && route_ok && clocked),
    .resync_i  (cfg.route == ROUTE_RESYNC),
    .rise_en_i (cfg.edge_sel[0]),
    .fall_en_i (cfg.edge_sel[1]),
    .sig_i     (sel_sig),
    .evt_o     (det_evt),
    .busy_o    (det_busy)
  );

  always_comb begin
    if (cfg.route == ROUTE_ASYNC) begin
      evt_o  = chan_en && route_ok && sel_sig;
      busy_o = 1'b0;
    end else begin
      evt_o  = det_evt;
      busy_o = det_busy;
    end
  end

  assign clk_req_o = chan_en && route_ok && (cfg.on_demand ? busy_o : 1'b1);

  // R3
  no_gen_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[5:0] == '0) |-> !evt_o && !busy_o && !clk_req_o);

  // R7
  rsvd_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[9:8] == 2'd3) |-> !evt_o && !busy_o && !clk_req_o);

  // R10
  stby_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_i && !cfg_rdata_o[14]) |-> !evt_o && !clk_req_o);
endmodule

// File: tb/sim_evt_route_chan.sv
`timescale 1ns/1ps
module sim_evt_route_chan;
  localparam int NG = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [31:0] wd = '0;
  logic [NG:1] gen = '0;
  logic stby = 1'b0;
  logic [31:0] rd0, rd1;
  logic ev0, bz0, cr0, ev1, bz1, cr1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_route_chan #(.CHAN_IDX(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we0), .cfg_wdata_i(wd), .cfg_rdata_o(rd0),
    .gen_i(gen), .standby_i(stby), .evt_o(ev0), .busy_o(bz0), .clk_req_o(cr0));

  evt_route_chan #(.CHAN_IDX(5)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we1), .cfg_wdata_i(wd), .cfg_rdata_o(rd1),
    .gen_i(gen), .standby_i(stby), .evt_o(ev1), .busy_o(bz1), .clk_req_o(cr1));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr0(input logic [31:0] w);
    wd = w; we0 = 1'b1; step(); we0 = 1'b0; step(4);
  endtask

  function automatic logic [31:0] mkcfg(input int od, input int rs, input int edg,
                                        input int rt, input int g);
    return (32'(od) << 15) | (32'(rs) << 14) | (32'(edg) << 10) | (32'(rt) << 8) | 32'(g);
  endfunction

  // drive one transition on gen[gi] for u0 and follow it cycle by cycle
  task automatic edge_run(input int gi, input logic nv, input int rt, input int edg,
                          input int od, input string tag);
    logic q;
    int lat;
    q   = (nv & edg[0]) | (!nv & edg[1]);
    lat = (rt == 0) ? 2 : 3;
    gen[gi] = nv;
    #1;
    chk(32'(bz0), 32'(q), {tag, " R12 busy on change"});
    chk(32'(cr0), od ? 32'(q) : 32'd1, {tag, " R11 clk_req"});
    for (int n = 1; n <= lat + 1; n++) begin
      step();
      chk(32'(ev0), 32'(q && n == lat), {tag, (rt == 0) ? " R4 evt" : " R5 evt"});
      chk(32'(bz0), 32'(q && n <= lat), {tag, " R12 busy"});
      chk(32'(cr0), od ? 32'(q && n <= lat) : 32'd1, {tag, " R11 clk_req"});
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int gl[4];
    gl = '{1, 17, 42, 63};
    #7; rst_n = 1'b1;
    step();
    // R1
    chk(rd0, 32'h0000_8000, "R1 reset cfg");
    chk(32'(ev0), 0, "R1 evt"); chk(32'(bz0), 0, "R1 busy"); chk(32'(cr0), 0, "R1 clk_req");

    // R2 masking
    wr0(32'hFFFF_FFFF); chk(rd0, 32'h0000_CF3F, "R2 all ones");
    wr0(32'hA5A5_5A5A); chk(rd0, 32'hA5A5_5A5A & 32'hCF3F, "R2 pattern a");
    wr0(32'h3C3C_30C0); chk(rd0, 32'h3C3C_30C0 & 32'hCF3F, "R2 pattern b");

    // R3 selector zero
    wr0(mkcfg(0, 0, 3, 0, 0));
    gen = '1; step(4);
    chk(32'(ev0), 0, "R3 sel0 evt"); chk(32'(bz0), 0, "R3 sel0 busy"); chk(32'(cr0), 0, "R3 sel0 clk_req");
    gen = '0; step(4);
    chk(32'(ev0), 0, "R3 sel0 evt fall");

    // R4 R5 R6 R11 R12 sweep
    for (int od = 0; od < 2; od++)
      for (int rt = 0; rt < 2; rt++)
        for (int edg = 0; edg < 4; edg++)
          for (int k = 0; k < 4; k++) begin
            int gi, nb;
            gi = gl[k];
            nb = (gi == NG) ? gi - 1 : gi + 1;
            gen = '0;
            wr0(mkcfg(od, 0, edg, rt, gi));
            chk(32'(cr0), od ? 32'd0 : 32'd1, "R11 idle clk_req");
            edge_run(gi, 1'b1, rt, edg, od, "R6 rise");
            edge_run(gi, 1'b0, rt, edg, od, "R6 fall");
            gen[nb] = 1'b1; step(4);
            chk(32'(ev0), 0, "R3 other line evt"); chk(32'(bz0), 0, "R3 other line busy");
            gen[nb] = 1'b0; step(4);
            chk(32'(ev0), 0, "R3 other line evt fall");
          end

    // R13 write with line already high
    for (int rt = 0; rt < 2; rt++) begin
      gen = '0;
      gen[20] = 1'b1;
      wd = mkcfg(0, 0, 3, rt, 20); we0 = 1'b1; step(); we0 = 1'b0;
      for (int n = 0; n < 5; n++) begin
        chk(32'(ev0), 0, "R13 no event after write");
        step();
      end
      edge_run(20, 1'b0, rt, 3, 0, "R13 then fall");
    end

    // R7 reserved route
    gen = '0;
    wr0(mkcfg(0, 0, 3, 3, 5));
    chk(32'(cr0), 0, "R7 clk_req");
    gen[5] = 1'b1; #1;
    chk(32'(ev0), 0, "R7 evt comb");
    step(4);
    chk(32'(ev0), 0, "R7 evt"); chk(32'(bz0), 0, "R7 busy");
    gen[5] = 1'b0; step(4);
    chk(32'(ev0), 0, "R7 evt fall");

    // R8 async route on index 0, edge field ignored
    for (int edg = 0; edg < 4; edg += 3) begin
      wr0(mkcfg(0, 0, edg, 2, 30));
      chk(rd0[9:8], 2'd2, "R8 route reads 2");
      gen[30] = 1'b1; #1;
      chk(32'(ev0), 1, "R8 async high"); chk(32'(bz0), 0, "R8 async busy");
      gen[30] = 1'b0; #1;
      chk(32'(ev0), 0, "R8 async low");
      step();
    end

    // R9 index 5 forces async
    for (int rt = 0; rt < 4; rt++) begin
      logic [31:0] w;
      w = mkcfg(0, 0, 1, rt, 9);
      wd = w; we1 = 1'b1; step(); we1 = 1'b0; step();
      chk(rd1, ((w & 32'hCF3F) & ~32'h300) | 32'h200, "R9 forced route readback");
      gen[9] = 1'b1; #1;
      chk(32'(ev1), 1, "R9 comb follow high");
      gen[9] = 1'b0; #1;
      chk(32'(ev1), 0, "R9 comb follow low");
      step();
    end

    // R10 standby
    gen = '0;
    wr0(mkcfg(0, 0, 1, 0, 3));
    stby = 1'b1; #1;
    chk(32'(cr0), 0, "R10 stopped clk_req");
    gen[3] = 1'b1; #1;
    chk(32'(bz0), 0, "R10 stopped busy");
    for (int n = 0; n < 4; n++) begin
      step(); chk(32'(ev0), 0, "R10 stopped evt");
    end
    gen[3] = 1'b0; step(); stby = 1'b0; step(3);
    chk(32'(ev0), 0, "R10 resume quiet");
    wr0(mkcfg(0, 1, 1, 1, 3));
    stby = 1'b1; #1;
    edge_run(3, 1'b1, 1, 1, 0, "R10 run in standby");
    edge_run(3, 1'b0, 1, 1, 0, "R10 run in standby");
    stby = 1'b0;
    step(2);

    done = 1;
    finish_run();
  end
endmodule